// File: doc/BRIEF.md
# Byte Write Mask Packer

The packer turns one byte-granular write into a sized byte-write request. The write arrives as a region address, a 32-byte data word and a 32-bit per-byte enable vector, where enable bit i refers to byte i of the 32-byte aligned region. The packer finds the lowest and highest dwords that hold at least one enabled byte. It sends only that span, which removes the empty dwords at both ends.

The request has two parts. A header holds the trimmed start address and the dword count. A payload stream starts with one 32-bit mask dword covering the whole region, followed by the data dwords of the span in ascending order. The header and the stream move together under one valid/ready handshake. A write with no enabled byte produces no request and raises a one-cycle drop flag. Splitting a write across regions and link framing are left to the surrounding logic.

Top module: `bwmp_top`

## Requirements
- R1: After synchronous active-low reset, `in_ready` is 1, and `out_valid` and `drop` are 0.
- R2: `out_addr` equals `in_addr` with bits [4:2] replaced by the index of the lowest dword holding an enabled byte and bits [1:0] zero. Input address bits [4:0] are ignored.
- R3: `out_count` is the total dword count including the mask dword, minus one. This equals the number of data dwords from the lowest to the highest dword holding an enabled byte, in the range 1 to 8.
- R4: The first beat of each request is the mask dword. Its bit i equals enable bit i of the region, so bits before the start, inside holes and after the last sent dword are zero.
- R5: After the mask, one beat is sent per dword from the lowest to the highest dword holding an enabled byte. Beat k carries `in_data[32*(first+k) +: 32]`, and dwords in between with no enabled byte are still sent.
- R6: `out_last` is 1 only on the final data beat and never on the mask beat.
- R7: While `out_valid` is 1 and `out_ready` is 0, the beat, `out_last`, `out_addr` and `out_count` hold unchanged.
- R8: An accepted write with an all-zero enable vector produces no beat. `drop` is 1 in the cycle after acceptance only, and `in_ready` stays 1.
- R9: `in_ready` is 0 while a request is being streamed. It returns to 1 in the cycle after the final beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write offered |
| in_ready | output | 1 | Packer idle and able to take a write |
| in_addr | input | ADDR_W | Region address; bits [4:0] ignored |
| in_data | input | 256 | Region data, byte i at bits [8i+7:8i] |
| in_byte_en | input | 32 | Per-byte enable, bit i for byte i |
| out_valid | output | 1 | Payload beat and header valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 32 | Mask dword, then data dwords |
| out_last | output | 1 | Final data beat |
| out_addr | output | ADDR_W | Trimmed dword-aligned start address |
| out_count | output | 4 | Total dwords including mask, minus one |
| drop | output | 1 | One-cycle pulse for an all-empty write |

## Verification
The bench sweeps all 256 patterns of which dwords are occupied, with a different nonzero byte pattern inside each occupied dword and nonzero ignored address bits. This covers single dwords at every position, the full region, and spans with interior holes. A design that trimmed with the wrong end, or used the raw address bits, would show a wrong start address or count. A design that skipped interior empty dwords, or placed `out_last` on the mask, would show a short stream or a misplaced end marker. Every third request stalls each beat for a cycle to catch data that moves under back-pressure. The empty pattern checks that no beat appears and that the drop pulse lasts exactly one cycle.

// File: rtl/bwmp_pkg.sv
// Package: shared constants and types for the byte write mask packer.
// Assumes a 32-byte region, 4-byte dwords and one 32-bit mask dword.
package bwmp_pkg;
    localparam int REGION_BYTES = 32;
    localparam int DW_BYTES     = 4;
    localparam int DW_BITS      = DW_BYTES * 8;
    localparam int DW_PER_REG   = REGION_BYTES / DW_BYTES;
    localparam int IDX_W        = $clog2(DW_PER_REG);
    localparam int CNT_W        = IDX_W + 1;
    localparam int REG_BITS     = REGION_BYTES * 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MASK = 2'd1,
        ST_DATA = 2'd2
    } bwmp_state_e;
endpackage

// File: rtl/bwmp_span_find.sv
// Module: bwmp_span_find
// Purpose: finds the lowest and highest dword of the region that hold
// at least one enabled byte. Purely combinational.
// Assumes: the enable vector has one bit per byte of the region.
module bwmp_span_find
    import bwmp_pkg::*;
(
    input  logic [REGION_BYTES-1:0] byte_en,
    output logic                    any_en,
    output logic [IDX_W-1:0]        first_idx,
    output logic [IDX_W-1:0]        last_idx
);
    logic [DW_PER_REG-1:0] dw_hit;

    // One occupancy flag per dword.
    for (genvar g = 0; g < DW_PER_REG; g++) begin : g_hit
        assign dw_hit[g] = |byte_en[g*DW_BYTES +: DW_BYTES];
    end

    // Priority search from both ends of the occupancy vector.
    always_comb begin
        first_idx = '0;
        last_idx  = '0;
        for (int d = DW_PER_REG - 1; d >= 0; d--) begin
            if (dw_hit[d]) first_idx = IDX_W'(d);
        end
        for (int d = 0; d < DW_PER_REG; d++) begin
            if (dw_hit[d]) last_idx = IDX_W'(d);
        end
    end

    assign any_en = |dw_hit;
endmodule

// File: rtl/bwmp_stream.sv
// Module: bwmp_stream
// Purpose: captures one write with its computed span and streams the
// mask dword followed by the data dwords of the span.
// Assumes: first_idx <= last_idx whenever any_en is set.
module bwmp_stream
    import bwmp_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [REG_BITS-1:0]     in_data,
    input  logic [REGION_BYTES-1:0] in_byte_en,
    input  logic                    any_en,
    input  logic [IDX_W-1:0]        first_idx,
    input  logic [IDX_W-1:0]        last_idx,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DW_BITS-1:0]      out_data,
    output logic                    out_last,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [CNT_W-1:0]        out_count,
    output logic                    drop
);
    localparam int OFS_W = IDX_W + 2;

    bwmp_state_e             state_q;
    logic [REG_BITS-1:0]     data_q;
    logic [REGION_BYTES-1:0] mask_q;
    logic [IDX_W-1:0]        idx_q;
    logic [IDX_W-1:0]        end_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    drop_q;
    logic                    take;
    logic                    beat_done;

    assign take      = in_valid && in_ready;
    assign beat_done = out_valid && out_ready;

    // Sequencer: idle, mask beat, then data beats up to the span end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            end_q   <= '0;
            drop_q  <= 1'b0;
        end else begin
            drop_q <= take && !any_en;
            case (state_q)
                ST_IDLE: if (take && any_en) begin
                    state_q <= ST_MASK;
                    idx_q   <= first_idx;
                    end_q   <= last_idx;
                end
                ST_MASK: if (beat_done) state_q <= ST_DATA;
                ST_DATA: if (beat_done) begin
                    if (idx_q == end_q) state_q <= ST_IDLE;
                    else                idx_q   <= idx_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Payload and header capture on acceptance of a non-empty write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (take && any_en) begin
            data_q <= in_data;
            mask_q <= in_byte_en;
            addr_q <= {in_addr[ADDR_W-1:OFS_W], first_idx, 2'b00};
            cnt_q  <= {1'b0, last_idx} - {1'b0, first_idx} + 1'b1;
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q != ST_IDLE);
    assign out_data  = (state_q == ST_MASK) ? DW_BITS'(mask_q)
                                            : data_q[{idx_q, 5'b0} +: DW_BITS];
    assign out_last  = (state_q == ST_DATA) && (idx_q == end_q);
    assign out_addr  = addr_q;
    assign out_count = cnt_q;
    assign drop      = drop_q;

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7
    AST_HOLD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_addr) && $stable(out_count)); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> !out_valid && in_ready); // R8
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[1:0] == 2'b00); // R2
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= 1) && (out_count <= CNT_W'(DW_PER_REG))); // R3
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready); // R6
    AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !drop || $past(in_valid)); // R8
endmodule

// File: rtl/bwmp_top.sv
// Module: bwmp_top
// Purpose: byte write mask packer top; joins the span search and the
// streaming sequencer.
// Assumes: one write per region; callers split multi-region writes.
module bwmp_top
    import bwmp_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [REG_BITS-1:0]     in_data,
    input  logic [REGION_BYTES-1:0] in_byte_en,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DW_BITS-1:0]      out_data,
    output logic                    out_last,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [CNT_W-1:0]        out_count,
    output logic                    drop
);
    logic             any_en;
    logic [IDX_W-1:0] first_idx;
    logic [IDX_W-1:0] last_idx;

    bwmp_span_find u_span (
        .byte_en   (in_byte_en),
        .any_en    (any_en),
        .first_idx (first_idx),
        .last_idx  (last_idx)
    );

    bwmp_stream #(.ADDR_W(ADDR_W)) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addr    (in_addr),
        .in_data    (in_data),
        .in_byte_en (in_byte_en),
        .any_en     (any_en),
        .first_idx  (first_idx),
        .last_idx   (last_idx),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_addr   (out_addr),
        .out_count  (out_count),
        .drop       (drop)
    );
endmodule

// File: tb/bwmp_top_tb.sv
// Bench: sweeps every dword-occupancy pattern of one region and checks
// header, mask, data beats, end marker, back-pressure and drop behaviour.
module bwmp_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 40;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr;
    logic [255:0]      in_data;
    logic [31:0]       in_byte_en;
    logic              out_valid;
    logic              out_ready;
    logic [31:0]       out_data;
    logic              out_last;
    logic [ADDR_W-1:0] out_addr;
    logic [3:0]        out_count;
    logic              drop;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bwmp_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_byte_en(in_byte_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_addr(out_addr), .out_count(out_count),
        .drop(drop)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic beat(input logic [31:0] exp_d, input logic exp_l, input bit stall,
                        input string req);
        if (stall) begin
            out_ready = 1'b0;
            @(negedge clk);
        end
        out_ready = 1'b1;
        chk("R7 valid held", 64'(out_valid), 64'd1);
        chk(req, 64'(out_data), 64'(exp_d));
        chk("R6 last", 64'(out_last), 64'(exp_l));
        chk("R9 busy", 64'(in_ready), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0;
        in_byte_en = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 drop", 64'(drop), 64'd0);

        for (int p = 0; p < 256; p++) begin
            logic [31:0] be;
            int f, l;
            bit stall;
            be = '0; f = -1; l = -1;
            stall = (p % 3 == 0);
            for (int d = 0; d < 8; d++) begin
                if (p[d]) begin
                    be[d*4 +: 4] = 4'(((p + d*5) % 15) + 1);
                    if (f < 0) f = d;
                    l = d;
                end
            end
            for (int i = 0; i < 32; i++) in_data[i*8 +: 8] = 8'((p*7 + i*13 + 5) & 8'hFF);
            in_addr    = 40'h12_3450_0000 + 40'(p*32) + 40'(p % 32);
            in_byte_en = be;
            in_valid   = 1'b1;
            chk("R9 ready idle", 64'(in_ready), 64'd1);
            @(negedge clk);
            in_valid = 1'b0;
            if (p == 0) begin
                chk("R8 drop pulse", 64'(drop), 64'd1);
                chk("R8 no beat", 64'(out_valid), 64'd0);
                chk("R8 ready kept", 64'(in_ready), 64'd1);
                @(negedge clk);
                chk("R8 drop one cycle", 64'(drop), 64'd0);
                chk("R8 still no beat", 64'(out_valid), 64'd0);
            end else begin
                logic [39:0] ea;
                ea = {in_addr[39:5], 3'(f), 2'b00};
                chk("R2 addr", 64'(out_addr), 64'(ea));
                chk("R3 count", 64'(out_count), 64'(l - f + 1));
                beat(be, 1'b0, stall, "R4 mask");
                for (int d = f; d <= l; d++) begin
                    chk("R7 hdr addr", 64'(out_addr), 64'(ea));
                    beat(in_data[d*32 +: 32], d == l, stall, "R5 data");
                end
                chk("R9 ready after", 64'(in_ready), 64'd1);
                chk("R6 stream ended", 64'(out_valid), 64'd0);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule